// File: doc/BRIEF.md
# OTP Fuse Controller Register Front-End

This block sits between a CPU register bus and a one-time-programmable fuse array. Software picks a command, a row address and up to two words of write data through registers. It then raises a start bit. The block runs the command against a simple request/acknowledge array port and flags completion in a status register. The commands are read, program, arm and disarm. A read leaves the row in read-data registers, where it stays until the next read completes. A program ORs new data into the addressed row, so fuse bits only ever go from 0 to 1.

Programming is guarded by a lock. To open it, software issues the arm command four times, each with its own start handshake, with the key values 0xF, 0x4, 0x8 and 0xD in the first write-data word, in that order. Any wrong key, or any other command issued before the fourth key, sends the sequence back to its first step. The disarm command closes the lock again. The row width is a parameter and may be one or two 32-bit words.

Top module: `fusectl_top`

## Requirements
- R1: After reset, every readable register returns 0: mode 0x00, command 0x04, start 0x08, status 0x0C, address 0x28 and read data 0x10/0x5C. Programming is locked.
- R2: While mode bit 0 is clear, writes to the start register are ignored. No command runs, the status stays 0 and the start register reads back 0.
- R3: The address register at 0x28 keeps only bits 15:0 of a write and reads back with the upper bits at 0. Its value selects the row used by read and program.
- R4: A command is accepted only when start bit 0 goes from 0 to 1. Writing 1 again while it is already 1 starts nothing. Writing 0 clears the done flag, which is status bit 1.
- R5: Read (command 0x00) fetches the addressed row into read word 0 at 0x10 and read word 1 at 0x5C, then sets status bit 1. The read words keep their value until the next read finishes.
- R6: Issuing arm (command 0x02) four times with first write word 0xF, 0x4, 0x8, 0xD in that order unlocks programming. Status bit 2 then reads 1.
- R7: A wrong key at any step, or any other command between steps, returns the sequence to its first step. The mismatching key does not itself count as a first step.
- R8: Program (command 0x08) while locked sets status bit 1, leaves status bit 2 at 0 and does not change the array.
- R9: Program while unlocked writes write word 0 at 0x2C and write word 1 at 0x64 into the addressed row. The row becomes the OR of its old contents and the new data. Status bit 1 sets once the array acknowledges, after a delay that varies.
- R10: Disarm (command 0x03) relocks programming and sets status bits 1 and 2 as its success indication. Bit 2 stays set until the next accepted command, after which later program commands are refused.
- R11: Any command code other than 0x00, 0x02, 0x03 and 0x08 sets status bit 1 without an array access and leaves the read words unchanged.
- R12: The command register at 0x04 keeps 6 bits and reads back with bits 31:6 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe for one cycle |
| reg_addr | input | BUS_AW (8) | Register byte offset |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Combinational read data for reg_addr |
| arr_req | output | 1 | Array request, held until acknowledged |
| arr_we | output | 1 | 1 for program, 0 for read |
| arr_addr | output | ADDR_W (16) | Row address |
| arr_wdata | output | ROW_WORDS*DATA_W (64) | Row data to OR into the fuses |
| arr_ack | input | 1 | One-cycle completion from the array |
| arr_rdata | input | ROW_WORDS*DATA_W (64) | Row contents, valid with arr_ack |

## Verification
The bench reads every row and then programs every row. It compares each result with an OR-accumulated mirror, so a design that overwrote bits, or latched the wrong word of a two-word row, shows a mismatch. It also sweeps all 60 undefined command codes: one that touched the array or disturbed the read words would be caught. Broken unlock sequences check the step reset: one with a bad key, one with a command in the middle. A checker that only advanced, or never reset its step, would open the lock there. The bench also re-raises start without clearing it and starts while access is off; a design that treated a level as an edge would run a second command.

// File: rtl/fusectl_pkg.sv
package fusectl_pkg;

  localparam int CMD_W   = 6;
  localparam int KEY_LEN = 4;

  // register byte offsets decoded by software
  localparam logic [7:0] OFF_MODE = 8'h00;
  localparam logic [7:0] OFF_CMD  = 8'h04;
  localparam logic [7:0] OFF_GO   = 8'h08;
  localparam logic [7:0] OFF_STAT = 8'h0C;
  localparam logic [7:0] OFF_RD0  = 8'h10;
  localparam logic [7:0] OFF_ADDR = 8'h28;
  localparam logic [7:0] OFF_WR0  = 8'h2C;
  localparam logic [7:0] OFF_RD1  = 8'h5C;
  localparam logic [7:0] OFF_WR1  = 8'h64;

  localparam logic [CMD_W-1:0] CMD_READ   = 6'h00;
  localparam logic [CMD_W-1:0] CMD_UNLOCK = 6'h02;
  localparam logic [CMD_W-1:0] CMD_LOCK   = 6'h03;
  localparam logic [CMD_W-1:0] CMD_PROG   = 6'h08;

  typedef enum logic {SQ_IDLE, SQ_ARRAY} seq_state_e;

  function automatic logic [31:0] unlock_key(input int idx);
    case (idx)
      0:       return 32'h0000_000F;
      1:       return 32'h0000_0004;
      2:       return 32'h0000_0008;
      default: return 32'h0000_000D;
    endcase
  endfunction

  function automatic logic [7:0] rd_off(input int w);
    return (w == 0) ? OFF_RD0 : OFF_RD1;
  endfunction

  function automatic logic [7:0] wr_off(input int w);
    return (w == 0) ? OFF_WR0 : OFF_WR1;
  endfunction

endpackage

// File: rtl/fusectl_regfile.sv
module fusectl_regfile
  import fusectl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int ROW_WORDS = 2,
  parameter int BUS_AW    = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [BUS_AW-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  input  logic                          done,
  input  logic                          ok,
  input  logic                          rd_load,
  input  logic [ROW_WORDS*DATA_W-1:0]   rd_row,
  output logic                          acc_en,
  output logic                          go_lvl,
  output logic [CMD_W-1:0]              cmd,
  output logic [ADDR_W-1:0]             row_addr,
  output logic [ROW_WORDS*DATA_W-1:0]   wr_row,
  output logic [ROW_WORDS*DATA_W-1:0]   rd_hold,
  output logic                          start_req,
  output logic                          go_clear
);

  localparam int ROW_W = ROW_WORDS * DATA_W;

  logic              acc_q;
  logic [CMD_W-1:0]  cmd_q;
  logic              go_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ROW_W-1:0]  wr_q;
  logic [ROW_W-1:0]  rd_q;

  logic hit_mode, hit_cmd, hit_go, hit_addr, go_wr;
  logic [ROW_WORDS-1:0] hit_wr;

  assign hit_mode = reg_we && (reg_addr == BUS_AW'(OFF_MODE));
  assign hit_cmd  = reg_we && (reg_addr == BUS_AW'(OFF_CMD));
  assign hit_go   = reg_we && (reg_addr == BUS_AW'(OFF_GO));
  assign hit_addr = reg_we && (reg_addr == BUS_AW'(OFF_ADDR));

  for (genvar w = 0; w < ROW_WORDS; w++) begin : g_wr_hit
    assign hit_wr[w] = reg_we && (reg_addr == BUS_AW'(wr_off(w)));
  end

  // start register only responds while CPU access is granted
  assign go_wr     = hit_go && acc_q;
  assign start_req = go_wr && reg_wdata[0] && !go_q;
  assign go_clear  = go_wr && !reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= 1'b0;
      cmd_q  <= '0;
      go_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      if (hit_mode) acc_q  <= reg_wdata[0];
      if (hit_cmd)  cmd_q  <= reg_wdata[CMD_W-1:0];
      if (go_wr)    go_q   <= reg_wdata[0];
      if (hit_addr) addr_q <= reg_wdata[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;
      rd_q <= '0;
    end else begin
      for (int w = 0; w < ROW_WORDS; w++) begin
        if (hit_wr[w]) wr_q[w*DATA_W +: DATA_W] <= reg_wdata;
        if (rd_load)   rd_q[w*DATA_W +: DATA_W] <= rd_row[w*DATA_W +: DATA_W];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      BUS_AW'(OFF_MODE): reg_rdata = DATA_W'(acc_q);
      BUS_AW'(OFF_CMD):  reg_rdata = DATA_W'(cmd_q);
      BUS_AW'(OFF_GO):   reg_rdata = DATA_W'(go_q);
      BUS_AW'(OFF_STAT): reg_rdata = DATA_W'({ok, done, 1'b0});
      BUS_AW'(OFF_ADDR): reg_rdata = DATA_W'(addr_q);
      default:           reg_rdata = '0;
    endcase
    for (int w = 0; w < ROW_WORDS; w++) begin
      if (reg_addr == BUS_AW'(rd_off(w))) reg_rdata = rd_q[w*DATA_W +: DATA_W];
      if (reg_addr == BUS_AW'(wr_off(w))) reg_rdata = wr_q[w*DATA_W +: DATA_W];
    end
  end

  assign acc_en   = acc_q;
  assign go_lvl   = go_q;
  assign cmd      = cmd_q;
  assign row_addr = addr_q;
  assign wr_row   = wr_q;
  assign rd_hold  = rd_q;

endmodule

// File: rtl/fusectl_unlock.sv
module fusectl_unlock
  import fusectl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic              relock,
  input  logic [CMD_W-1:0]  cmd,
  input  logic [DATA_W-1:0] key,
  output logic              unlocked
);

  localparam int STEP_W = $clog2(KEY_LEN);

  logic [STEP_W-1:0] step_q, step_d;
  logic              unl_q, unl_d;
  logic              key_hit;

  assign key_hit = (key == DATA_W'(unlock_key(int'(step_q))));

  always_comb begin
    step_d = step_q;
    unl_d  = unl_q;
    if (relock) unl_d = 1'b0;
    if (start_ok) begin
      if (cmd == CMD_UNLOCK && key_hit) begin
        if (step_q == STEP_W'(KEY_LEN - 1)) begin
          unl_d  = 1'b1;
          step_d = '0;
        end else begin
          step_d = step_q + 1'b1;
        end
      end else begin
        step_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      unl_q  <= 1'b0;
    end else begin
      step_q <= step_d;
      unl_q  <= unl_d;
    end
  end

  assign unlocked = unl_q;

endmodule

// File: rtl/fusectl_seq.sv
module fusectl_seq
  import fusectl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             go_clear,
  input  logic             unlocked,
  input  logic             arr_ack,
  input  logic [CMD_W-1:0] cmd,
  output logic             start_ok,
  output logic             relock,
  output logic             rd_load,
  output logic             done,
  output logic             dis_ok,
  output logic             arr_req,
  output logic             arr_we
);

  seq_state_e st_q, st_d;
  logic done_q, done_d;
  logic ok_q, ok_d;
  logic we_q, we_d;

  assign start_ok = start_req && (st_q == SQ_IDLE);

  always_comb begin
    st_d    = st_q;
    done_d  = done_q;
    ok_d    = ok_q;
    we_d    = we_q;
    relock  = 1'b0;
    rd_load = 1'b0;
    if (go_clear) done_d = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (start_ok) begin
          done_d = 1'b0;
          ok_d   = 1'b0;
          case (cmd)
            CMD_READ: begin
              st_d = SQ_ARRAY;
              we_d = 1'b0;
            end
            CMD_PROG: begin
              if (unlocked) begin
                st_d = SQ_ARRAY;
                we_d = 1'b1;
              end else begin
                done_d = 1'b1;
              end
            end
            CMD_LOCK: begin
              relock = 1'b1;
              ok_d   = 1'b1;
              done_d = 1'b1;
            end
            default: done_d = 1'b1;
          endcase
        end
      end
      SQ_ARRAY: begin
        if (arr_ack) begin
          st_d    = SQ_IDLE;
          done_d  = 1'b1;
          rd_load = !we_q;
        end
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      ok_q   <= ok_d;
      we_q   <= we_d;
    end
  end

  assign done    = done_q;
  assign dis_ok  = ok_q;
  assign arr_req = (st_q == SQ_ARRAY);
  assign arr_we  = we_q;

endmodule

// File: rtl/fusectl_top.sv
module fusectl_top
  import fusectl_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 16,
  parameter int ROW_WORDS = 2,
  parameter int BUS_AW    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        reg_we,
  input  logic [BUS_AW-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  output logic                        arr_req,
  output logic                        arr_we,
  output logic [ADDR_W-1:0]           arr_addr,
  output logic [ROW_WORDS*DATA_W-1:0] arr_wdata,
  input  logic                        arr_ack,
  input  logic [ROW_WORDS*DATA_W-1:0] arr_rdata
);

  localparam int ROW_W = ROW_WORDS * DATA_W;

  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic             acc_en, go_lvl, start_req, go_clear, start_ok;
  logic             relock, rd_load, done, dis_ok, unlocked, status_ok;
  logic [CMD_W-1:0] cmd;
  logic [ROW_W-1:0] wr_row, rd_hold;

  assign status_ok = unlocked || dis_ok;

  fusectl_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ROW_WORDS(ROW_WORDS), .BUS_AW(BUS_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_s),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .done(done), .ok(status_ok), .rd_load(rd_load), .rd_row(arr_rdata),
    .acc_en(acc_en), .go_lvl(go_lvl), .cmd(cmd), .row_addr(arr_addr),
    .wr_row(wr_row), .rd_hold(rd_hold), .start_req(start_req), .go_clear(go_clear)
  );

  fusectl_seq u_seq (
    .clk(clk), .rst_n(rst_s),
    .start_req(start_req), .go_clear(go_clear), .unlocked(unlocked),
    .arr_ack(arr_ack), .cmd(cmd),
    .start_ok(start_ok), .relock(relock), .rd_load(rd_load),
    .done(done), .dis_ok(dis_ok), .arr_req(arr_req), .arr_we(arr_we)
  );

  fusectl_unlock #(.DATA_W(DATA_W)) u_lock (
    .clk(clk), .rst_n(rst_s),
    .start_ok(start_ok), .relock(relock), .cmd(cmd),
    .key(wr_row[DATA_W-1:0]), .unlocked(unlocked)
  );

  assign arr_wdata = wr_row;

endmodule

// File: rtl/fusectl_chk.sv
module fusectl_chk
  import fusectl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BUS_AW = 8,
  parameter int ROW_W  = 64
) (
  input logic              clk,
  input logic              rst_s,
  input logic              reg_we,
  input logic [BUS_AW-1:0] reg_addr,
  input logic              go_bit,
  input logic              acc_en,
  input logic              go_lvl,
  input logic              start_ok,
  input logic [CMD_W-1:0]  cmd,
  input logic [DATA_W-1:0] key,
  input logic              unlocked,
  input logic              dis_ok,
  input logic              done,
  input logic              arr_req,
  input logic              arr_we,
  input logic              arr_ack,
  input logic [ROW_W-1:0]  rd_hold
);

  logic go_hit;
  assign go_hit = reg_we && (reg_addr == BUS_AW'(OFF_GO));

  assert_go_ignored_R2: assert property (@(posedge clk) disable iff (!rst_s)
    (go_hit && !acc_en) |=> $stable(go_lvl));

  assert_clear_done_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (go_hit && acc_en && !go_bit && !arr_ack) |=> !done);

  assert_level_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (go_lvl && start_ok) |-> 1'b0);

  assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_s)
    !(arr_ack && !arr_we) |=> $stable(rd_hold));

  assert_unlock_last_key_R6: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(unlocked) |-> $past(start_ok && cmd == CMD_UNLOCK && key == DATA_W'(32'hD)));

  assert_prog_needs_unlock_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (arr_req && arr_we) |-> unlocked);

  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (arr_req && !arr_ack) |=> arr_req);

  assert_disarm_relocks_R10: assert property (@(posedge clk) disable iff (!rst_s)
    (start_ok && cmd == CMD_LOCK) |=> (!unlocked && dis_ok && done));

endmodule

bind fusectl_top fusectl_chk #(
  .DATA_W(DATA_W), .BUS_AW(BUS_AW), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst_s(rst_s), .reg_we(reg_we), .reg_addr(reg_addr),
  .go_bit(reg_wdata[0]), .acc_en(acc_en), .go_lvl(go_lvl), .start_ok(start_ok),
  .cmd(cmd), .key(wr_row[DATA_W-1:0]), .unlocked(unlocked), .dis_ok(dis_ok),
  .done(done), .arr_req(arr_req), .arr_we(arr_we), .arr_ack(arr_ack),
  .rd_hold(rd_hold)
);

// File: tb/fusectl_top_tb.sv
module fusectl_array_model #(
  parameter int ROWS   = 16,
  parameter int ROW_W  = 64,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ROW_W-1:0]  wdata,
  output logic              ack,
  output logic [ROW_W-1:0]  rdata
);
  logic [ROW_W-1:0] mem [ROWS];
  logic             busy;
  logic [3:0]       cnt;

  function automatic logic [31:0] seed(input int r, input int w);
    return 32'h5A00_0000 ^ (r * 32'h0001_0203) ^ (w * 32'h0F00_0000);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < ROWS; r++)
        mem[r] <= {seed(r, 1), seed(r, 0)};
      busy  <= 1'b0;
      cnt   <= '0;
      ack   <= 1'b0;
      rdata <= '0;
    end else begin
      ack <= 1'b0;
      if (!busy && req && !ack) begin
        busy <= 1'b1;
        cnt  <= we ? 4'(2 + addr[2:0]) : 4'(1 + addr[1:0]);
      end else if (busy) begin
        if (cnt == 0) begin
          busy <= 1'b0;
          ack  <= 1'b1;
          if (we) mem[addr[3:0]] <= mem[addr[3:0]] | wdata;
          else    rdata <= mem[addr[3:0]];
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

module fusectl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 16;

  localparam logic [7:0] A_MODE = 8'h00, A_CMD = 8'h04, A_GO = 8'h08, A_STAT = 8'h0C;
  localparam logic [7:0] A_RD0 = 8'h10, A_ADDR = 8'h28, A_WR0 = 8'h2C, A_RD1 = 8'h5C, A_WR1 = 8'h64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        arr_req, arr_we, arr_ack;
  logic [15:0] arr_addr;
  logic [63:0] arr_wdata, arr_rdata;

  int errors = 0;
  int checks = 0;
  logic [31:0] expm [ROWS][2];

  always #(CLK_PERIOD/2) clk = ~clk;

  fusectl_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arr_req(arr_req),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_ack(arr_ack), .arr_rdata(arr_rdata)
  );

  fusectl_array_model #(.ROWS(ROWS), .ROW_W(64), .ADDR_W(16)) u_arr (
    .clk(clk), .rst_n(rst_n), .req(arr_req), .we(arr_we), .addr(arr_addr),
    .wdata(arr_wdata), .ack(arr_ack), .rdata(arr_rdata)
  );

  function automatic logic [31:0] seed(input int r, input int w);
    return 32'h5A00_0000 ^ (r * 32'h0001_0203) ^ (w * 32'h0F00_0000);
  endfunction

  function automatic logic [31:0] pdata(input int r, input int w);
    return (32'h1 << r) | (32'h8000_0000 >> (r + w)) | (w << 20);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // issue a command, wait for done (bounded), return status, clear start
  task automatic run_cmd(input logic [5:0] c, output logic [31:0] st);
    logic [31:0] s;
    wr(A_CMD, {26'd0, c});
    wr(A_GO, 32'h1);
    s = '0;
    for (int i = 0; i < 40; i++) begin
      rd(A_STAT, s);
      if (s[1]) break;
    end
    st = s;
    wr(A_GO, 32'h0);
  endtask

  task automatic read_row(input int r, output logic [31:0] w0, output logic [31:0] w1,
                          output logic [31:0] st);
    wr(A_ADDR, r);
    run_cmd(6'h00, st);
    rd(A_RD0, w0);
    rd(A_RD1, w1);
  endtask

  task automatic arm_step(input logic [31:0] k, output logic [31:0] st);
    wr(A_WR0, k);
    run_cmd(6'h02, st);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, w0, w1, st;
    for (int r = 0; r < ROWS; r++) begin
      expm[r][0] = seed(r, 0);
      expm[r][1] = seed(r, 1);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_MODE, v); check("R1 mode", v, 0);
    rd(A_CMD, v);  check("R1 cmd", v, 0);
    rd(A_GO, v);   check("R1 go", v, 0);
    rd(A_STAT, v); check("R1 status", v, 0);
    rd(A_ADDR, v); check("R1 addr", v, 0);
    rd(A_RD0, v);  check("R1 rd0", v, 0);
    rd(A_RD1, v);  check("R1 rd1", v, 0);

    // R2 start ignored without access
    wr(A_ADDR, 3);
    wr(A_CMD, 0);
    wr(A_GO, 1);
    repeat (12) @(negedge clk);
    rd(A_STAT, v); check("R2 status", v, 0);
    rd(A_GO, v);   check("R2 go", v, 0);
    rd(A_RD0, v);  check("R2 rd0", v, 0);

    wr(A_MODE, 1);
    rd(A_MODE, v); check("R2 mode set", v, 1);

    // R3 and R12 field widths
    wr(A_ADDR, 32'hABCD_1234);
    rd(A_ADDR, v); check("R3 addr mask", v, 32'h0000_1234);
    wr(A_CMD, 32'hFFFF_FFFF);
    rd(A_CMD, v);  check("R12 cmd mask", v, 32'h0000_003F);

    // R5 read sweep across all rows
    for (int r = 0; r < ROWS; r++) begin
      read_row(r, w0, w1, st);
      check("R5 read done", {31'd0, st[1]}, 1);
      check("R5 rd word0", w0, expm[r][0]);
      check("R5 rd word1", w1, expm[r][1]);
    end

    // R11 sweep of undefined codes; read words must hold row 15
    for (int c = 0; c < 64; c++) begin
      if (c == 0 || c == 2 || c == 3 || c == 8) continue;
      wr(A_ADDR, c % ROWS);
      run_cmd(6'(c), st);
      check("R11 done only", st, 32'h2);
      rd(A_RD0, v);
      check("R11 rd0 held", v, expm[15][0]);
    end

    // R4 re-writing 1 while high starts nothing; writing 0 clears done
    wr(A_ADDR, 1);
    wr(A_CMD, 0);
    wr(A_GO, 1);
    repeat (12) @(negedge clk);
    rd(A_RD0, v);  check("R4 first read", v, expm[1][0]);
    wr(A_ADDR, 2);
    wr(A_GO, 1);
    repeat (12) @(negedge clk);
    rd(A_RD0, v);  check("R4 no restart", v, expm[1][0]);
    rd(A_STAT, v); check("R4 done kept", v, 32'h2);
    wr(A_GO, 0);
    rd(A_STAT, v); check("R4 done cleared", v, 0);

    // R8 program while locked
    wr(A_ADDR, 2);
    wr(A_WR0, 32'hFFFF_FFFF);
    wr(A_WR1, 32'hFFFF_FFFF);
    run_cmd(6'h08, st);
    check("R8 status", st, 32'h2);
    read_row(2, w0, w1, st);
    check("R8 row2 w0", w0, expm[2][0]);
    check("R8 row2 w1", w1, expm[2][1]);

    // R7 wrong key restarts
    arm_step(32'hF, st); arm_step(32'h4, st); arm_step(32'h7, st);
    arm_step(32'h8, st); arm_step(32'hD, st);
    check("R7 bad key stays locked", st, 32'h2);
    // R7 mismatching key does not count as first step
    arm_step(32'hF, st); arm_step(32'hF, st); arm_step(32'h4, st);
    arm_step(32'h8, st); arm_step(32'hD, st);
    check("R7 repeated first key locked", st, 32'h2);
    // R7 other command mid-sequence restarts
    arm_step(32'hF, st); arm_step(32'h4, st);
    wr(A_ADDR, 0);
    run_cmd(6'h00, st);
    arm_step(32'h8, st); arm_step(32'hD, st);
    check("R7 interleaved read locked", st, 32'h2);

    // R6 full sequence
    arm_step(32'hF, st); check("R6 step1", st, 32'h2);
    arm_step(32'h4, st); check("R6 step2", st, 32'h2);
    arm_step(32'h8, st); check("R6 step3", st, 32'h2);
    arm_step(32'hD, st); check("R6 unlocked", st, 32'h6);

    // R9 program sweep with OR semantics
    for (int r = 0; r < ROWS; r++) begin
      wr(A_ADDR, r);
      wr(A_WR0, pdata(r, 0));
      wr(A_WR1, pdata(r, 1));
      run_cmd(6'h08, st);
      check("R9 prog done", st, 32'h6);
      expm[r][0] = expm[r][0] | pdata(r, 0);
      expm[r][1] = expm[r][1] | pdata(r, 1);
    end
    for (int r = 0; r < ROWS; r++) begin
      read_row(r, w0, w1, st);
      check("R9 row w0", w0, expm[r][0]);
      check("R9 row w1", w1, expm[r][1]);
    end

    // R10 disarm
    run_cmd(6'h03, st);
    check("R10 disarm status", st, 32'h6);
    rd(A_STAT, v); check("R10 ok kept after clear", v, 32'h4);
    read_row(5, w0, w1, st);
    check("R10 ok cleared by next cmd", st, 32'h2);
    wr(A_ADDR, 5);
    wr(A_WR0, 32'hFFFF_FFFF);
    wr(A_WR1, 32'hFFFF_FFFF);
    run_cmd(6'h08, st);
    check("R10 prog refused", st, 32'h2);
    read_row(5, w0, w1, st);
    check("R10 row5 w0", w0, expm[5][0]);
    check("R10 row5 w1", w1, expm[5][1]);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule